// File: doc/BRIEF.md
# Asynchronous Bus Write Qualifier

This block sits between an asynchronous parallel memory bus and the synchronous command logic of a memory device. It watches three active-low strobes: chip select, write strobe and output enable. From them it decides whether a legal write cycle has taken place. For each accepted cycle it captures one address and one data word. It then hands them to the clock domain as a single-cycle command pulse. Interpreting the command is left to the logic downstream.

The strobes, the supply lockout input and the bus address and data are sampled through two register stages each, so the strobes and the bus values stay aligned in time. A state machine then follows each cycle through these states:

- `ST_PWRUP`: power-up guard.
- `ST_IDLE`: waiting for a cycle.
- `ST_LOW`: both strobes low; measuring the low time.
- `ST_WAIT`: aborted cycle; waiting for the strobes to release.
- `ST_LOCK`: supply lockout.

Transitions:

| From | To | Condition |
|---|---|---|
| reset | `ST_PWRUP` | always |
| `ST_PWRUP` | `ST_IDLE` | chip select or write strobe goes high; no command is produced |
| `ST_IDLE` | `ST_LOW` | chip select and write strobe both low while output enable is high |
| `ST_LOW` | `ST_IDLE` | a strobe rises; a command is emitted if the cycle qualifies |
| `ST_LOW` | `ST_WAIT` | output enable drops during the cycle |
| `ST_WAIT` | `ST_IDLE` | a strobe is released |
| any state | `ST_LOCK` | lockout is seen |
| `ST_LOCK` | `ST_PWRUP` | lockout clears |

Top module: `wr_cycle_qualifier`

## Requirements
- R1: A cycle in which chip select and write strobe are both low, output enable is high, and the joint low time is at least MIN_LOW clock cycles produces exactly one `cmd_valid` pulse.
- R2: `cmd_addr` carries the bus address present when the later of the two strobes fell.
- R3: `cmd_data` carries the bus data present just before the earlier of the two strobes rose. Data that changes together with or after that rising edge is not taken.
- R4: Output enable low blocks a write. This holds when it is low for the whole cycle, and also when it drops while both strobes are low. Neither case produces a pulse.
- R5: A joint low time of fewer than MIN_LOW cycles produces no pulse.
- R6: While `lockout` is high, no pulse is produced. `cmd_reset` is high within three cycles of `lockout` rising and low within three cycles of it falling.
- R7: If both strobes are low when reset is released, the first strobe release produces no pulse. Later cycles are accepted normally.
- R8: `cmd_valid` lasts exactly one cycle. `cmd_addr` and `cmd_data` hold their last values until the next pulse, including across rejected cycles.
- R9: After reset, `cmd_valid` and `cmd_reset` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip select, active low, asynchronous |
| we_n | input | 1 | Bus write strobe, active low, asynchronous |
| oe_n | input | 1 | Bus output enable, active low, asynchronous |
| lockout | input | 1 | High when the supply is below the lockout level |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data |
| cmd_valid | output | 1 | One-cycle strobe for an accepted write |
| cmd_addr | output | AW | Captured address, held between pulses |
| cmd_data | output | DW | Captured data, held between pulses |
| cmd_reset | output | 1 | Holds downstream command logic in reset during lockout |

## Verification
Writes are driven with both strobe orders on the falling side and on the rising side, while address and data change between the two edges. This shows whether capture follows the later fall and the earlier rise, rather than one fixed strobe.

Low times of exactly MIN_LOW cycles and of one cycle less separate the accepted width from the rejected one. Output enable held low, and output enable dropped in mid-cycle, each test one of the two inhibit paths.

Lockout cycles and a reset taken with the strobes already low test the two supply-related guards. Each is followed by a normal write, which shows that the guard releases again.

// File: rtl/wq_pkg.sv
package wq_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_LOW   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_LOCK  = 3'd4
    } wq_state_e;
endpackage

// File: rtl/wq_sync.sv
// Two register stages per bit; used for the strobes and, with the same
// latency, for bus address and data so that both views stay aligned.
module wq_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wq_width_cnt.sv
// Saturating low-time counter for the glitch filter.
module wq_width_cnt #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic inc,
    output logic long_enough
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(1);
        else if (inc && cnt_q < LIMIT)
            cnt_q <= cnt_q + CW'(1);
    end

    assign long_enough = (cnt_q >= LIMIT);
endmodule

// File: rtl/wr_cycle_qualifier.sv
module wr_cycle_qualifier #(
    parameter int AW      = 18,
    parameter int DW      = 16,
    parameter int MIN_LOW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          lockout,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data,
    output logic          cmd_reset
);
    import wq_pkg::*;

    localparam int BW = AW + DW;

    // synchronised strobes {lock, oe, we, ce}; reset shows ce/we low so the
    // power-up guard waits for real bus values before leaving ST_PWRUP
    logic [3:0]    strb_s;
    logic [BW-1:0] bus_s;
    logic          ce_s, we_s, oe_s, lock_s;
    logic          both_low, act, long_enough;

    wq_sync #(.W(4), .RST_VAL(4'b0000)) u_strb_sync (
        .clk (clk), .rst_n (rst_n),
        .d   ({lockout, oe_n, we_n, ce_n}),
        .q   (strb_s)
    );

    wq_sync #(.W(BW), .RST_VAL('0)) u_bus_align (
        .clk (clk), .rst_n (rst_n),
        .d   ({bus_addr, bus_data}),
        .q   (bus_s)
    );

    assign ce_s     = strb_s[0];
    assign we_s     = strb_s[1];
    assign oe_s     = strb_s[2];
    assign lock_s   = strb_s[3];
    assign both_low = !ce_s && !we_s;
    assign act      = both_low && oe_s;

    wq_state_e state_q, state_d;

    logic cnt_start, cnt_inc, exit_ok;
    assign cnt_start = (state_q == ST_IDLE) && act && !lock_s;
    assign cnt_inc   = (state_q == ST_LOW) && both_low;
    assign exit_ok   = (state_q == ST_LOW) && !lock_s && !both_low
                       && oe_s && long_enough;

    wq_width_cnt #(.MIN_LOW(MIN_LOW)) u_width (
        .clk (clk), .rst_n (rst_n),
        .start (cnt_start), .inc (cnt_inc),
        .long_enough (long_enough)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (lock_s) begin
            state_d = ST_LOCK;
        end else begin
            unique case (state_q)
                ST_PWRUP: if (ce_s || we_s) state_d = ST_IDLE;
                ST_IDLE:  if (act)          state_d = ST_LOW;
                ST_LOW: begin
                    if (!both_low)  state_d = ST_IDLE;
                    else if (!oe_s) state_d = ST_WAIT;
                end
                ST_WAIT:  if (ce_s || we_s) state_d = ST_IDLE;
                ST_LOCK:  state_d = ST_PWRUP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    // capture and outputs
    logic [AW-1:0] addr_hold;
    logic [DW-1:0] data_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold <= '0;
            data_hold <= '0;
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            cmd_reset <= 1'b0;
        end else begin
            cmd_reset <= lock_s;
            cmd_valid <= exit_ok;
            if (cnt_start)
                addr_hold <= bus_s[BW-1:DW];
            if (act)
                data_hold <= bus_s[DW-1:0];
            if (exit_ok) begin
                cmd_addr <= addr_hold;
                cmd_data <= data_hold;
            end
        end
    end
endmodule

// File: rtl/wq_checker.sv
module wq_checker #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [AW-1:0]     cmd_addr,
    input logic [DW-1:0]     cmd_data,
    input logic              cmd_reset,
    input logic              oe_s,
    input logic              lock_s,
    input logic              long_enough,
    input wq_pkg::wq_state_e state_q
);
    import wq_pkg::*;

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R8

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(cmd_addr) && $stable(cmd_data))); // R8

    AST_OE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(oe_s)); // R4

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(long_enough)); // R5

    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |-> !cmd_valid); // R6

    AST_LOCK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_s |=> (state_q == ST_LOCK)); // R6
endmodule

bind wr_cycle_qualifier wq_checker #(.AW(AW), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .cmd_reset   (cmd_reset),
    .oe_s        (oe_s),
    .lock_s      (lock_s),
    .long_enough (long_enough),
    .state_q     (state_q)
);

// File: tb/wr_cycle_qualifier_tb_top.sv
module wr_cycle_qualifier_tb_top;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int MIN_LOW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lockout = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic cmd_valid, cmd_reset;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int run = 0;
    int max_run = 0;

    always #4 clk = ~clk;

    wr_cycle_qualifier #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n), .lockout (lockout),
        .bus_addr (bus_addr), .bus_data (bus_data),
        .cmd_valid (cmd_valid), .cmd_addr (cmd_addr),
        .cmd_data (cmd_data), .cmd_reset (cmd_reset)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            pulses <= pulses + 1;
            run    <= run + 1;
            if (run + 1 > max_run) max_run <= run + 1;
        end else begin
            run <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic ce0, input logic we0);
        @(negedge clk);
        rst_n = 1'b0; ce_n = ce0; we_n = we0; oe_n = 1'b1; lockout = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // plain write with both strobes falling and rising together
    task automatic plain_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int low);
        @(negedge clk);
        bus_addr = a; bus_data = d;
        ce_n = 1'b0; we_n = 1'b0;
        cyc(low);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(6);
    endtask

    task automatic t_reset_state();
        do_reset(1'b1, 1'b1);
        cyc(3);
        chk(cmd_valid == 1'b0, "R9 cmd_valid", cmd_valid, 0);
        chk(cmd_reset == 1'b0, "R9 cmd_reset", cmd_reset, 0);
    endtask

    task automatic t_basic();
        int p0 = pulses;
        plain_write(18'h12345, 16'hBEEF, 6);
        chk(pulses == p0 + 1, "R1 pulse count", pulses - p0, 1);
        chk(cmd_addr == 18'h12345, "R1 addr", cmd_addr, 18'h12345);
        chk(cmd_data == 16'hBEEF, "R1 data", cmd_data, 16'hBEEF);
        chk(max_run == 1, "R8 pulse width", max_run, 1);
    endtask

    task automatic t_addr_later(input bit ce_first);
        int p0 = pulses;
        @(negedge clk);
        bus_addr = 18'h00AAA; bus_data = 16'h1111;
        if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
        cyc(2);
        bus_addr = 18'h00BBB;
        cyc(1);
        if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
        cyc(6);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(6);
        chk(pulses == p0 + 1, "R2 pulse", pulses - p0, 1);
        chk(cmd_addr == 18'h00BBB, "R2 later-fall addr", cmd_addr, 18'h00BBB);
    endtask

    task automatic t_data_first(input bit we_first);
        int p0 = pulses;
        @(negedge clk);
        bus_addr = 18'h00321; bus_data = 16'hD1D1;
        ce_n = 1'b0; we_n = 1'b0;
        cyc(6);
        if (we_first) we_n = 1'b1; else ce_n = 1'b1;
        bus_data = 16'hD2D2;
        cyc(2);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(6);
        chk(pulses == p0 + 1, "R3 pulse", pulses - p0, 1);
        chk(cmd_data == 16'hD1D1, "R3 first-rise data", cmd_data, 16'hD1D1);
    endtask

    task automatic t_oe_block();
        int p0 = pulses;
        @(negedge clk);
        oe_n = 1'b0; bus_addr = 18'h3FFFF; bus_data = 16'h0BAD;
        ce_n = 1'b0; we_n = 1'b0;
        cyc(8);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(2);
        oe_n = 1'b1;
        cyc(4);
        chk(pulses == p0, "R4 oe low whole cycle", pulses - p0, 0);
        ce_n = 1'b0; we_n = 1'b0;
        cyc(5);
        oe_n = 1'b0;
        cyc(3);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(2);
        oe_n = 1'b1;
        cyc(6);
        chk(pulses == p0, "R4 oe drop mid-cycle", pulses - p0, 0);
        chk(cmd_addr != 18'h3FFFF, "R8 addr held after rejection", cmd_addr, 0);
    endtask

    task automatic t_glitch();
        int p0 = pulses;
        logic [AW-1:0] a_prev = cmd_addr;
        plain_write(18'h01234, 16'h5555, MIN_LOW - 1);
        chk(pulses == p0, "R5 short pulse rejected", pulses - p0, 0);
        chk(cmd_addr == a_prev, "R8 addr held", cmd_addr, a_prev);
        plain_write(18'h04321, 16'h6666, MIN_LOW);
        chk(pulses == p0 + 1, "R5 exact width accepted", pulses - p0, 1);
        chk(cmd_data == 16'h6666, "R5 data", cmd_data, 16'h6666);
    endtask

    task automatic t_lockout();
        int p0 = pulses;
        @(negedge clk);
        lockout = 1'b1;
        cyc(3);
        chk(cmd_reset == 1'b1, "R6 cmd_reset high", cmd_reset, 1);
        plain_write(18'h00777, 16'h7777, 6);
        chk(pulses == p0, "R6 no write in lockout", pulses - p0, 0);
        lockout = 1'b0;
        cyc(3);
        chk(cmd_reset == 1'b0, "R6 cmd_reset low", cmd_reset, 0);
        plain_write(18'h00888, 16'h8888, 6);
        chk(pulses == p0 + 1, "R6 write after lockout", pulses - p0, 1);
    endtask

    task automatic t_powerup();
        int p0;
        do_reset(1'b0, 1'b0);
        p0 = pulses;
        bus_addr = 18'h00999; bus_data = 16'h9999;
        cyc(6);
        we_n = 1'b1;
        cyc(2);
        ce_n = 1'b1;
        cyc(6);
        chk(pulses == p0, "R7 no command at power-up release", pulses - p0, 0);
        plain_write(18'h00ABC, 16'hABCD, 6);
        chk(pulses == p0 + 1, "R7 later write accepted", pulses - p0, 1);
        chk(cmd_addr == 18'h00ABC, "R7 addr", cmd_addr, 18'h00ABC);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_basic();
        t_addr_later(1'b1);
        t_addr_later(1'b0);
        t_data_first(1'b1);
        t_data_first(1'b0);
        t_oe_block();
        t_glitch();
        t_lockout();
        t_powerup();
        chk(max_run == 1, "R8 final pulse width", max_run, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule